// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by software into asynchronous serial frames on one output line. A write places a byte in a holding register. Whenever the shift stage is idle and the holding register is full, the byte moves across and the shift stage begins sending. Software can therefore queue the next byte while the current one is still on the line, and consecutive frames leave with no idle gap between them.

Each bit lasts a fixed number of pulses of a bit-rate enable that runs at sixteen times the bit rate. Configuration inputs select the frame shape:

- seven, eight or nine data bits;
- an optional parity bit of one of four kinds in the seven- and eight-bit shapes;
- one or two stop bits.

In the nine-bit shape, one of the two parity-select inputs supplies the ninth data bit instead. A break input forces the line low. A reinitialise input returns the block to a quiet state without erasing the holding register. A level interrupt request reports an empty holding register while it is enabled.

Top module: `sertx_core`

## Requirements
- R1: Synchronous reset drives these outputs: `txd`=1, `buf_empty`=1, `busy`=0 and `irq`=0.
- R2: Frame timing and levels.
  - A frame is a start bit of 0, then the data bits least significant first, then any parity or ninth bit, then stop bits of 1.
  - The line rests at 1 between frames.
  - Every bit lasts exactly 16 cycles in which `tick_16x` is high.
  - While `tick_16x` is low, the line does not advance.
- R3: `fmt_len` selects the number of data bits: 2'b00 gives 8, 2'b01 gives 7, and 2'b10 or 2'b11 gives 9. In the 7-bit shape, bit 7 of the byte is not sent.
- R4: Parity in the 7- and 8-bit shapes.
  - When `par_on` is 1, one parity bit follows the data.
  - `par_kind` chooses the parity bit: 2'b00 odd (total ones, parity included, is odd), 2'b01 even, 2'b10 constant 1, 2'b11 constant 0.
- R5: In the 9-bit shape, the ninth data bit is `par_kind[0]`. `par_on` is ignored and no parity bit is added.
- R6: `stop_two`=0 sends one stop bit; `stop_two`=1 sends two.
- R7: Write, transfer and back-to-back frames.
  - A write (`wr_en`=1 at clock edge W) stores `wr_data`, and `buf_empty` is 0 after edge W.
  - If the shifter is idle, the byte transfers at edge W+1: the start bit appears and `buf_empty` returns to 1.
  - The format inputs are taken at the transfer.
  - A byte waiting while a frame is sent transfers at the edge ending that frame's last stop bit, so the next start bit follows with no idle bit.
- R8: A write at the same edge as a transfer keeps the new byte in the holding register. `buf_empty` stays 0 and the new byte is sent after the current frame.
- R9: `busy` is 1 from the transfer edge until the edge ending the last stop bit of the last queued frame.
- R10: While `brk` is 1, `txd` is 0, whether the block is idle or mid-frame. Frame timing continues underneath, and the line follows the frame again once `brk` is released.
- R11: `irq` is high exactly when `buf_empty` and `irq_en` are both 1, as a level.
- R12: A reinitialise pulse (`reinit`=1 at an edge) has these effects after that edge:
  - `buf_empty` is 1, `busy` is 0 and `txd` is 1.
  - A byte that was waiting is never sent.
  - The block accepts and sends new writes as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | Bit-rate enable, sixteen per bit |
| wr_en | input | 1 | Software write strobe for the holding register |
| wr_data | input | 8 | Byte to queue |
| fmt_len | input | 2 | Data-bit count select |
| par_on | input | 1 | Parity enable (7/8-bit shapes) |
| par_kind | input | 2 | Parity kind; bit 0 is the ninth bit in the 9-bit shape |
| stop_two | input | 1 | Two stop bits when 1 |
| brk | input | 1 | Force the line low |
| irq_en | input | 1 | Interrupt enable |
| reinit | input | 1 | Reinitialise strobe |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding register empty |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Level interrupt request |

## Verification
The hazardous coincidence is a software write landing on the same edge as the transfer out of the holding register. The transfer wants to mark the holding register empty, while the write wants to mark it full. The bench writes one byte and then a second byte on the very next cycle, which is exactly the transfer edge of the first. It then expects `buf_empty` to stay 0 and both frames to leave back to back, first byte then second, with no idle bit between them. A second coincidence, the end of a frame meeting a waiting byte, is judged by requiring `busy` to stay high and the next start bit to appear in the cycle right after the previous stop bit ends.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = 12;                     // start + 9 data + 2 stop
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        LEN_8  = 2'b00,
        LEN_7  = 2'b01,
        LEN_9  = 2'b10,
        LEN_9B = 2'b11
    } len_e;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;    // bit 0 leaves first
        logic [LEN_W-1:0]   nbits;
    } frame_t;

    function automatic frame_t build_frame(
        input logic [DATA_W-1:0] d,
        input len_e              len,
        input logic              pen,
        input logic [1:0]        psel,
        input logic              stop2
    );
        frame_t            f;
        int                ndm;
        logic              has_x;
        logic              xb;
        logic [DATA_W-1:0] dm;
        int                total;
        ndm   = (len == LEN_7) ? 7 : 8;
        dm    = (len == LEN_7) ? {1'b0, d[6:0]} : d;
        has_x = (len == LEN_9) || (len == LEN_9B) || pen;
        if ((len == LEN_9) || (len == LEN_9B)) begin
            xb = psel[0];
        end else begin
            case (par_e'(psel))
                PAR_ODD:  xb = ~(^dm);
                PAR_EVEN: xb = ^dm;
                PAR_MARK: xb = 1'b1;
                default:  xb = 1'b0;
            endcase
        end
        f.bits    = '1;
        f.bits[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < ndm) f.bits[i+1] = d[i];
        end
        for (int i = 1; i < FRAME_W; i++) begin
            if (has_x && (i == ndm + 1)) f.bits[i] = xb;
        end
        total   = 1 + ndm + (has_x ? 1 : 0) + (stop2 ? 2 : 1);
        f.nbits = LEN_W'(total);
        return f;
    endfunction

endpackage

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic bit_end
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_end = tick && (cnt == LAST);

    // R2: without a tick the position inside the bit holds
    p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(cnt));

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reinit,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] data_q,
    output logic              full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full   <= 1'b0;
        end else if (reinit) begin
            full   <= 1'b0;
        end else begin
            if (wr_en) data_q <= wr_data;
            if (wr_en)     full <= 1'b1;
            else if (take) full <= 1'b0;
        end
    end

    // R8: a write always wins over a transfer in the same cycle
    p_write_fills_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !reinit) |=> full);

    // R7: a transfer without a write empties the holding stage
    p_take_empties_r7: assert property (@(posedge clk) disable iff (rst)
        (take && !wr_en && !reinit) |=> !full);

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   reinit,
    input  logic   load,
    input  frame_t frame_in,
    input  logic   bit_end,
    output logic   line,
    output logic   busy,
    output logic   on_last
);
    logic [FRAME_W-1:0] sh;
    logic [LEN_W-1:0]   left;

    always_ff @(posedge clk) begin
        if (rst || reinit) begin
            sh   <= '1;
            left <= '0;
        end else if (load) begin
            sh   <= frame_in.bits;
            left <= frame_in.nbits;
        end else if (bit_end && (left != '0)) begin
            sh   <= {1'b1, sh[FRAME_W-1:1]};
            left <= left - 1'b1;
        end
    end

    assign line    = sh[0];
    assign busy    = (left != '0);
    assign on_last = (left == LEN_W'(1));

    // R2: every frame opens with a low start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        (load && !reinit) |=> (!line && busy));

    // R2: mid-bit the shifter does not move
    p_bit_steady_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && !bit_end && !load && !reinit) |=> $stable(sh));

endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_16x,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [1:0] fmt_len,
    input  logic       par_on,
    input  logic [1:0] par_kind,
    input  logic       stop_two,
    input  logic       brk,
    input  logic       irq_en,
    input  logic       reinit,
    output logic       txd,
    output logic       buf_empty,
    output logic       busy,
    output logic       irq
);
    logic [DATA_W-1:0] hold_data;
    logic              hold_full;
    logic              take;
    logic              bit_end;
    logic              sh_line;
    logic              sh_busy;
    logic              sh_last;
    logic              tmr_clr;
    frame_t            frame;

    assign frame   = build_frame(hold_data, len_e'(fmt_len), par_on, par_kind, stop_two);
    assign take    = hold_full && !reinit && (!sh_busy || (bit_end && sh_last));
    assign tmr_clr = take || reinit || !sh_busy;

    sertx_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .reinit  (reinit),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .data_q  (hold_data),
        .full    (hold_full)
    );

    sertx_bit_timer #(.TICKS(TICKS_PER_BIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .tick    (tick_16x),
        .bit_end (bit_end)
    );

    sertx_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .reinit   (reinit),
        .load     (take),
        .frame_in (frame),
        .bit_end  (bit_end),
        .line     (sh_line),
        .busy     (sh_busy),
        .on_last  (sh_last)
    );

    assign txd       = brk ? 1'b0 : sh_line;
    assign buf_empty = !hold_full;
    assign busy      = sh_busy;
    assign irq       = buf_empty && irq_en;

    // R7: a frame only starts from a filled holding register
    p_start_needs_byte_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(hold_full));

    // R12: reinitialise leaves an empty, quiet block
    p_reinit_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        reinit |=> (buf_empty && !busy && (txd || brk)));

    // R2: idle line rests high unless a break is applied
    p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !brk) |-> txd);

    // R11: a write withdraws the request on the next cycle
    p_write_drops_irq_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !reinit) |=> !irq);

endmodule

// File: tb/sertx_core_tb.sv
module sertx_core_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_16x = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] fmt_len = '0;
    logic       par_on = 1'b0;
    logic [1:0] par_kind = '0;
    logic       stop_two = 1'b0;
    logic       brk = 1'b0;
    logic       irq_en = 1'b0;
    logic       reinit = 1'b0;
    logic       txd, buf_empty, busy, irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    sertx_core u_dut (
        .clk(clk), .rst(rst), .tick_16x(tick_16x), .wr_en(wr_en), .wr_data(wr_data),
        .fmt_len(fmt_len), .par_on(par_on), .par_kind(par_kind), .stop_two(stop_two),
        .brk(brk), .irq_en(irq_en), .reinit(reinit),
        .txd(txd), .buf_empty(buf_empty), .busy(busy), .irq(irq)
    );

    // {data, fmt_len, par_on, par_kind, stop_two, expected bit count, expected extra bit}
    localparam logic [18:0] VEC [10] = '{
        {8'h55, 2'b00, 1'b0, 2'b00, 1'b0, 4'd10, 1'b0},
        {8'hA3, 2'b00, 1'b1, 2'b00, 1'b0, 4'd11, 1'b1},
        {8'hA3, 2'b00, 1'b1, 2'b01, 1'b1, 4'd12, 1'b0},
        {8'h07, 2'b01, 1'b1, 2'b00, 1'b0, 4'd10, 1'b0},
        {8'hF7, 2'b01, 1'b1, 2'b10, 1'b1, 4'd11, 1'b1},
        {8'h3C, 2'b00, 1'b1, 2'b11, 1'b0, 4'd11, 1'b0},
        {8'h81, 2'b10, 1'b1, 2'b01, 1'b0, 4'd11, 1'b1},
        {8'hFF, 2'b11, 1'b0, 2'b10, 1'b1, 4'd12, 1'b0},
        {8'hAA, 2'b01, 1'b0, 2'b00, 1'b1, 4'd10, 1'b0},
        {8'h01, 2'b00, 1'b1, 2'b01, 1'b0, 4'd11, 1'b1}
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        wr_en   = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_start();
        int guard = 0;
        while (txd !== 1'b0 && guard < 400) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // samples each bit at its middle; returns at the negedge right after nb bits
    task automatic grab(input int nb, output logic [15:0] got, output logic ended, output logic held);
        got  = '1;
        held = 1'b1;
        wait_start();
        for (int c = 0; c < 16 * nb; c++) begin
            if (c % 16 == 8) got[c/16] = txd;
            if (busy !== 1'b1) held = 1'b0;
            @(negedge clk);
        end
        ended = (busy === 1'b0);
    endtask

    function automatic logic [15:0] expect_frame(input logic [18:0] v);
        logic [15:0] e;
        int          dn;
        logic        hx;
        dn = (v[10:9] == 2'b01) ? 7 : 8;
        hx = v[10] | v[8];
        e = '1;
        e[0] = 1'b0;
        for (int i = 0; i < 8; i++) if (i < dn) e[i+1] = v[11+i];
        for (int i = 1; i < 16; i++) if (hx && i == dn + 1) e[i] = v[0];
        return e;
    endfunction

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [15:0] got;
        logic [15:0] exp_f;
        logic [15:0] mask;
        logic        ended;
        logic        held;
        int          nb;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(txd === 1'b1, "R1 txd", 32'(txd), 1);
        chk(buf_empty === 1'b1, "R1 buf_empty", 32'(buf_empty), 1);
        chk(busy === 1'b0, "R1 busy", 32'(busy), 0);
        chk(irq === 1'b0, "R1 irq", 32'(irq), 0);
        rst = 1'b0;
        @(negedge clk);

        // table of formats: R2 R3 R4 R5 R6
        for (int v = 0; v < 10; v++) begin
            fmt_len  = VEC[v][10:9];
            par_on   = VEC[v][8];
            par_kind = VEC[v][7:6];
            stop_two = VEC[v][5];
            nb       = int'(VEC[v][4:1]);
            write_byte(VEC[v][18:11]);
            grab(nb, got, ended, held);
            exp_f = expect_frame(VEC[v]);
            mask  = 16'((32'd1 << nb) - 1);
            chk(((got ^ exp_f) & mask) == '0, "R2 R3 R4 R5 R6 frame bits",
                32'(got & mask), 32'(exp_f & mask));
            chk(ended && held, "R2 R6 frame length", {30'd0, ended, held}, 3);
        end

        // R7 R11 flag timing and back-to-back frames
        fmt_len = 2'b00; par_on = 1'b0; stop_two = 1'b0; irq_en = 1'b1;
        @(negedge clk);
        chk(irq === 1'b1, "R11 irq when empty and enabled", 32'(irq), 1);
        write_byte(8'hFF);
        chk(buf_empty === 1'b0, "R7 buf_empty after write", 32'(buf_empty), 0);
        chk(irq === 1'b0, "R11 irq after write", 32'(irq), 0);
        chk(busy === 1'b0, "R7 not yet started", 32'(busy), 0);
        @(negedge clk);
        chk(buf_empty && busy && (txd === 1'b0), "R7 transfer one cycle later",
            {29'd0, buf_empty, busy, txd}, 3'b110);
        chk(irq === 1'b1, "R11 irq after transfer", 32'(irq), 1);
        write_byte(8'h00);
        chk(buf_empty === 1'b0, "R7 queued during frame", 32'(buf_empty), 0);
        repeat (158) @(negedge clk);
        chk(txd === 1'b1 && busy === 1'b1, "R7 R9 last stop bit of first frame",
            {30'd0, txd, busy}, 3);
        @(negedge clk);
        chk(txd === 1'b0 && busy === 1'b1 && buf_empty === 1'b1, "R7 R9 no gap between frames",
            {29'd0, txd, busy, buf_empty}, 3'b011);
        grab(10, got, ended, held);
        chk(got[9:0] == 10'b10_0000_0000 && ended && held, "R7 second frame",
            {20'd0, ended, held, got[9:0]}, {20'd0, 2'b11, 10'b1000000000});

        // R8 write on the transfer edge
        write_byte(8'h0F);
        write_byte(8'hF0);
        chk(buf_empty === 1'b0 && txd === 1'b0, "R8 buf_empty stays 0 with first frame running",
            {30'd0, buf_empty, txd}, 0);
        grab(10, got, ended, held);
        chk(got[9:0] == 10'b10_0001_1110 && !ended && held, "R8 first frame",
            {20'd0, ended, held, got[9:0]}, {20'd0, 2'b01, 10'b1000011110});
        grab(10, got, ended, held);
        chk(got[9:0] == 10'b11_1110_0000 && ended && held, "R8 second byte sent",
            {20'd0, ended, held, got[9:0]}, {20'd0, 2'b11, 10'b1111100000});

        // R10 break while idle and mid-frame
        brk = 1'b1;
        @(negedge clk);
        chk(txd === 1'b0 && busy === 1'b0, "R10 break idle", {30'd0, txd, busy}, 0);
        brk = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1, "R10 release idle", 32'(txd), 1);
        write_byte(8'hFF);
        wait_start();
        repeat (40) @(negedge clk);
        chk(txd === 1'b1, "R10 data before break", 32'(txd), 1);
        brk = 1'b1;
        @(negedge clk);
        chk(txd === 1'b0 && busy === 1'b1, "R10 break mid-frame", {30'd0, txd, busy}, 1);
        brk = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1, "R10 line follows frame after release", 32'(txd), 1);
        repeat (117) @(negedge clk);
        chk(busy === 1'b1, "R10 timing kept to last cycle", 32'(busy), 1);
        @(negedge clk);
        chk(busy === 1'b0, "R10 frame ends on time", 32'(busy), 0);

        // R2 no advance without tick
        write_byte(8'hFF);
        wait_start();
        tick_16x = 1'b0;
        repeat (40) @(negedge clk);
        chk(txd === 1'b0 && busy === 1'b1, "R2 start bit held without ticks", {30'd0, txd, busy}, 1);
        tick_16x = 1'b1;
        repeat (159) @(negedge clk);
        chk(busy === 1'b1, "R2 stretched frame still running", 32'(busy), 1);
        @(negedge clk);
        chk(busy === 1'b0, "R2 stretched frame ends", 32'(busy), 0);

        // R12 reinitialise mid-frame with a byte waiting
        write_byte(8'h00);
        wait_start();
        repeat (20) @(negedge clk);
        write_byte(8'h33);
        chk(buf_empty === 1'b0, "R12 byte waiting", 32'(buf_empty), 0);
        reinit = 1'b1;
        @(negedge clk);
        reinit = 1'b0;
        chk(txd === 1'b1 && busy === 1'b0 && buf_empty === 1'b1, "R12 quiet after reinit",
            {29'd0, txd, busy, buf_empty}, 3'b101);
        chk(irq === 1'b1, "R11 R12 irq after reinit", 32'(irq), 1);
        repeat (300) @(negedge clk);
        chk(busy === 1'b0 && txd === 1'b1, "R12 waiting byte dropped", {30'd0, busy, txd}, 1);
        write_byte(8'h5A);
        grab(10, got, ended, held);
        chk(got[9:0] == 10'b10_1011_0100 && ended && held, "R12 normal after reinit",
            {20'd0, ended, held, got[9:0]}, {20'd0, 2'b11, 10'b1010110100});

        finish_run();
    end

endmodule